// File: doc/BRIEF.md
# Limited-Pointer Directory Sharer Entry

This block keeps the record of which nodes hold a copy of one memory line, in a directory entry of fixed width for a machine of 16 nodes. While at most two nodes share the line, the entry keeps two exact node pointers. When a third sharer arrives, the entry follows one of three overflow policies, picked by an input at the moment the overflow happens. It can set a broadcast flag. It can displace one pointer and have that node invalidated at once. Or it can reinterpret its storage as an 8-bit coarse vector, in which each bit stands for a pair of adjacent nodes.

The entry accepts one command per cycle: add a sharer, clear the entry, or a write by a given node. A write produces a 16-bit invalidation target mask, derived from whatever representation is active. The writer is always left out of that mask, and the entry then records the writer as its only holder. Messaging and acknowledgement collection live outside the block.

Top module: `dirent_lp`

## Requirements
- R1: After reset, and one cycle after a clear command (op 2), the entry is empty in pointer form: `overflow` is 0, `inv_valid` is 0, and a following write yields an all-zero mask.
- R2: An add (op 1) of a node that is not yet present fills the lowest free pointer slot. A write (op 3) raises `inv_valid` for exactly the cycle after the command, with `inv_mask` bit n set for each recorded sharer n.
- R3: Adding a node that already holds a pointer changes nothing, and no invalidation is issued.
- R4: With mode 2 or 3 (coarse), adding a third distinct sharer sets `overflow`. In the same cycle it sets the group bits of both existing pointers and of the new node, where group g covers nodes 2g and 2g+1.
- R5: In coarse form, each further add sets the group bit of that node. A write then targets both nodes of every marked group.
- R6: With mode 0 (broadcast), the overflowing add sets `overflow` and a broadcast flag. Later adds have no effect, and the next write targets all 16 nodes.
- R7: With mode 1 (evict), the overflowing add replaces a pointer slot, chosen round-robin starting at slot 0 after reset, clear or write. It pulses `inv_valid` the next cycle with a one-hot `inv_mask` of the displaced node, and `overflow` stays 0.
- R8: The writer's own bit is never set in the mask of its write.
- R9: After a write, the entry is in pointer form holding only the writer, with `overflow` 0.
- R10: `ovf_mode` matters only on the add that overflows. Once overflowed, the representation stays until a clear or a write. Op 0 does nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cmd_valid | input | 1 | Command present this cycle |
| cmd_op | input | 2 | 0 none, 1 add sharer, 2 clear, 3 write |
| cmd_node | input | 4 | Sharer being added, or the writer |
| ovf_mode | input | 2 | 0 broadcast, 1 evict, 2 and 3 coarse vector |
| inv_valid | output | 1 | Invalidation mask is valid (one cycle after the command) |
| inv_mask | output | 16 | Nodes to invalidate |
| overflow | output | 1 | Entry is in broadcast or coarse form |

## Verification
Directed sequences drive each overflow policy with known node sets. The coarse case uses sharers in different pairs, so that the group expansion shows whether partner nodes get marked. The evict case uses four successive sharers, which shows the round-robin victim order and the one-hot displacement report. The broadcast case checks that later adds are swallowed. Random streams mix adds of repeated and new nodes, mode changes after overflow, writes by present and absent nodes, and clears. Each result is compared against a bench model, which tells apart a missing writer exclusion, a wrong victim slot, and a mode that is sampled after the overflow has happened.

// File: rtl/dirent_pkg.sv
package dirent_pkg;

    typedef enum logic [1:0] {
        CMD_NONE  = 2'd0,
        CMD_ADD   = 2'd1,
        CMD_CLEAR = 2'd2,
        CMD_WRITE = 2'd3
    } dir_cmd_e;

    typedef enum logic [1:0] {
        OVF_BCAST      = 2'd0,
        OVF_EVICT      = 2'd1,
        OVF_COARSE     = 2'd2,
        OVF_COARSE_ALT = 2'd3
    } ovf_mode_e;

endpackage

// File: rtl/dirent_slot_match.sv
module dirent_slot_match #(
    parameter int NODE_W = 4,
    parameter int PTRS   = 2
) (
    input  logic [PTRS*NODE_W-1:0] store,
    input  logic [PTRS-1:0]        pv,
    input  logic [NODE_W-1:0]      node,
    output logic [PTRS-1:0]        hit,
    output logic [PTRS-1:0]        free_first
);
    for (genvar s = 0; s < PTRS; s++) begin : g_slot
        assign hit[s] = pv[s] && (store[s*NODE_W +: NODE_W] == node);
    end

    always_comb begin
        logic found;
        found      = 1'b0;
        free_first = '0;
        for (int s = 0; s < PTRS; s++) begin
            if (!pv[s] && !found) begin
                free_first[s] = 1'b1;
                found         = 1'b1;
            end
        end
    end
endmodule

// File: rtl/dirent_mask_expand.sv
module dirent_mask_expand #(
    parameter int NODES  = 16,
    parameter int NODE_W = 4,
    parameter int PTRS   = 2,
    parameter int GROUP  = 2
) (
    input  logic [PTRS*NODE_W-1:0] store,
    input  logic [PTRS-1:0]        pv,
    input  logic                   ovf,
    input  logic                   bcast,
    output logic [NODES-1:0]       mask
);
    for (genvar n = 0; n < NODES; n++) begin : g_node
        logic ptr_hit;
        always_comb begin
            ptr_hit = 1'b0;
            for (int s = 0; s < PTRS; s++) begin
                if (pv[s] && (store[s*NODE_W +: NODE_W] == NODE_W'(n)))
                    ptr_hit = 1'b1;
            end
        end
        assign mask[n] = bcast | (ovf ? store[n / GROUP] : ptr_hit);
    end
endmodule

// File: rtl/dirent_lp.sv
module dirent_lp
    import dirent_pkg::*;
#(
    parameter int NODES = 16,
    parameter int PTRS  = 2,
    parameter int GROUP = 2,
    localparam int NODE_W  = $clog2(NODES),
    localparam int STORE_W = PTRS * NODE_W,
    localparam int CV_W    = NODES / GROUP,
    localparam int GRP_SH  = $clog2(GROUP),
    localparam int PIDX_W  = (PTRS > 1) ? $clog2(PTRS) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    input  logic [1:0]        cmd_op,
    input  logic [NODE_W-1:0] cmd_node,
    input  logic [1:0]        ovf_mode,
    output logic              inv_valid,
    output logic [NODES-1:0]  inv_mask,
    output logic              overflow
);
    typedef struct packed {
        logic [STORE_W-1:0] store;
        logic [PTRS-1:0]    pv;
        logic               ovf;
        logic               bcast;
        logic [PIDX_W-1:0]  rr;
        logic               inv_v;
        logic [NODES-1:0]   inv_m;
    } ent_t;

    ent_t q, d;

    logic [PTRS-1:0]  hit, free_first;
    logic [NODES-1:0] cur_mask;

    dirent_slot_match #(.NODE_W(NODE_W), .PTRS(PTRS)) u_match (
        .store      (q.store),
        .pv         (q.pv),
        .node       (cmd_node),
        .hit        (hit),
        .free_first (free_first)
    );

    dirent_mask_expand #(.NODES(NODES), .NODE_W(NODE_W), .PTRS(PTRS), .GROUP(GROUP)) u_expand (
        .store (q.store),
        .pv    (q.pv),
        .ovf   (q.ovf),
        .bcast (q.bcast),
        .mask  (cur_mask)
    );

    dir_cmd_e  op;
    ovf_mode_e mode;
    assign op   = dir_cmd_e'(cmd_op);
    assign mode = ovf_mode_e'(ovf_mode);

    logic [STORE_W-1:0] node_grp_bit;
    assign node_grp_bit = STORE_W'(1) << (cmd_node >> GRP_SH);

    always_comb begin
        logic [STORE_W-1:0] cv;
        logic [NODE_W-1:0]  victim;
        d       = q;
        d.inv_v = 1'b0;
        d.inv_m = '0;
        cv      = '0;
        victim  = '0;
        for (int s = 0; s < PTRS; s++) begin
            if (q.pv[s])
                cv = cv | (STORE_W'(1) << (q.store[s*NODE_W +: NODE_W] >> GRP_SH));
            if (PIDX_W'(s) == q.rr)
                victim = q.store[s*NODE_W +: NODE_W];
        end
        if (cmd_valid) begin
            case (op)
                CMD_ADD: begin
                    if (q.ovf) begin
                        if (!q.bcast)
                            d.store = q.store | node_grp_bit;
                    end else if (|hit) begin
                        d = d;
                    end else if (|free_first) begin
                        for (int s = 0; s < PTRS; s++) begin
                            if (free_first[s]) begin
                                d.store[s*NODE_W +: NODE_W] = cmd_node;
                                d.pv[s] = 1'b1;
                            end
                        end
                    end else begin
                        case (mode)
                            OVF_BCAST: begin
                                d.ovf   = 1'b1;
                                d.bcast = 1'b1;
                            end
                            OVF_EVICT: begin
                                d.inv_v = 1'b1;
                                d.inv_m = NODES'(1) << victim;
                                for (int s = 0; s < PTRS; s++) begin
                                    if (PIDX_W'(s) == q.rr)
                                        d.store[s*NODE_W +: NODE_W] = cmd_node;
                                end
                                d.rr = (q.rr == PIDX_W'(PTRS - 1)) ? '0 : q.rr + 1'b1;
                            end
                            default: begin
                                d.store = (cv | node_grp_bit) & {{(STORE_W-CV_W){1'b0}}, {CV_W{1'b1}}};
                                d.pv    = '0;
                                d.ovf   = 1'b1;
                            end
                        endcase
                    end
                end
                CMD_CLEAR: begin
                    d.store = '0;
                    d.pv    = '0;
                    d.ovf   = 1'b0;
                    d.bcast = 1'b0;
                    d.rr    = '0;
                end
                CMD_WRITE: begin
                    d.inv_v = 1'b1;
                    d.inv_m = cur_mask & ~(NODES'(1) << cmd_node);
                    d.store = STORE_W'(cmd_node);
                    d.pv    = PTRS'(1);
                    d.ovf   = 1'b0;
                    d.bcast = 1'b0;
                    d.rr    = '0;
                end
                default: d = d;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign inv_valid = q.inv_v;
    assign inv_mask  = q.inv_m;
    assign overflow  = q.ovf;

    // writer exclusion
    assert_writer_excluded_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_op == CMD_WRITE) |=> ((inv_mask & (NODES'(1) << $past(cmd_node))) == '0));

    assert_write_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_op == CMD_WRITE) |=> inv_valid);

    assert_write_pointer_form_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_op == CMD_WRITE) |=> !overflow);

    assert_clear_empty_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_op == CMD_CLEAR) |=> (!overflow && !inv_valid && q.pv == '0));

    assert_dup_add_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_op == CMD_ADD && !q.ovf && (|hit)) |=>
            ($stable(q.store) && $stable(q.pv) && !inv_valid));

    assert_evict_onehot_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (inv_valid && !$past(cmd_valid && cmd_op == CMD_WRITE)) |-> ($countones(inv_mask) == 1));

    assert_bcast_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (q.bcast && cmd_valid && cmd_op == CMD_ADD) |=> (q.bcast && overflow && !inv_valid));
endmodule

// File: tb/dirent_lp_tb.sv
module dirent_lp_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_valid = 1'b0;
    logic [1:0]  cmd_op = 2'd0;
    logic [3:0]  cmd_node = 4'd0;
    logic [1:0]  ovf_mode = 2'd0;
    logic        inv_valid;
    logic [15:0] inv_mask;
    logic        overflow;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    dirent_lp u_dut (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_node(cmd_node), .ovf_mode(ovf_mode), .inv_valid(inv_valid),
        .inv_mask(inv_mask), .overflow(overflow)
    );

    // bench model of the entry
    logic [3:0] m_slot [2];
    logic       m_pv   [2];
    logic [7:0] m_cv;
    logic       m_ovf, m_bc;
    int         m_rr;

    task automatic model_clear();
        m_slot[0] = 0; m_slot[1] = 0; m_pv[0] = 0; m_pv[1] = 0;
        m_cv = 0; m_ovf = 0; m_bc = 0; m_rr = 0;
    endtask

    function automatic logic [15:0] model_cover();
        logic [15:0] m = 0;
        if (m_bc) return 16'hFFFF;
        for (int n = 0; n < 16; n++) begin
            if (m_ovf) m[n] = m_cv[n/2];
            else m[n] = (m_pv[0] && m_slot[0] == 4'(n)) || (m_pv[1] && m_slot[1] == 4'(n));
        end
        return m;
    endfunction

    task automatic check(string req, logic ev, logic [15:0] em, logic eo);
        checks++;
        if (inv_valid !== ev || (ev && inv_mask !== em) || overflow !== eo) begin
            errors++;
            $display("FAIL %s: got valid=%0b mask=%04h ovf=%0b, expected valid=%0b mask=%04h ovf=%0b",
                     req, inv_valid, inv_mask, overflow, ev, em, eo);
        end
    endtask

    // one command; model gives expected values, checked one edge later
    task automatic run(logic [1:0] op, logic [3:0] node, logic [1:0] mode);
        logic ev = 0; logic [15:0] em = 0; string req = "R10";
        if (op == 2'd1) begin
            req = "R2";
            if (m_ovf) begin
                if (!m_bc) begin m_cv[node/2] = 1; req = "R5"; end else req = "R6";
            end else if ((m_pv[0] && m_slot[0] == node) || (m_pv[1] && m_slot[1] == node)) begin
                req = "R3";
            end else if (!m_pv[0]) begin m_slot[0] = node; m_pv[0] = 1;
            end else if (!m_pv[1]) begin m_slot[1] = node; m_pv[1] = 1;
            end else if (mode == 2'd0) begin m_ovf = 1; m_bc = 1; req = "R6";
            end else if (mode == 2'd1) begin
                req = "R7"; ev = 1; em = 16'(1) << m_slot[m_rr];
                m_slot[m_rr] = node; m_rr = 1 - m_rr;
            end else begin
                req = "R4"; m_cv = 0;
                m_cv[m_slot[0]/2] = 1; m_cv[m_slot[1]/2] = 1; m_cv[node/2] = 1;
                m_ovf = 1; m_pv[0] = 0; m_pv[1] = 0;
            end
        end else if (op == 2'd2) begin
            req = "R1"; model_clear();
        end else if (op == 2'd3) begin
            req = "R8"; ev = 1; em = model_cover() & ~(16'(1) << node);
            model_clear(); m_slot[0] = node; m_pv[0] = 1;
        end
        @(negedge clk);
        cmd_valid = (op != 2'd0); cmd_op = op; cmd_node = node; ovf_mode = mode;
        @(posedge clk); #1;
        check(req, ev, em, m_ovf);
    endtask

    // directed step with hand-computed expectation
    task automatic step(string req, logic [1:0] op, logic [3:0] node, logic [1:0] mode,
                        logic ev, logic [15:0] em, logic eo);
        @(negedge clk);
        cmd_valid = 1; cmd_op = op; cmd_node = node; ovf_mode = mode;
        @(posedge clk); #1;
        check(req, ev, em, eo);
    endtask

    initial begin
        #(5 * 150000);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog: got timeout, expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd2718));
        model_clear();
        repeat (3) @(posedge clk);
        #1; check("R1 reset", 0, 0, 0);
        @(negedge clk); rst_n = 1;

        // R1: empty write
        step("R1 empty write", 2'd3, 4'd4, 2'd0, 1, 16'h0000, 0);
        step("R1 clear", 2'd2, 4'd0, 2'd0, 0, 0, 0);
        // R4/R5: coarse with groups 1,4,6 then write by 0
        step("R2 add", 2'd1, 4'd3, 2'd2, 0, 0, 0);
        step("R2 add", 2'd1, 4'd8, 2'd2, 0, 0, 0);
        step("R3 dup", 2'd1, 4'd8, 2'd2, 0, 0, 0);
        step("R4 overflow", 2'd1, 4'd13, 2'd2, 0, 0, 1);
        step("R10 mode after ovf", 2'd1, 4'd12, 2'd0, 0, 0, 1);
        step("R5 coarse write", 2'd3, 4'd0, 2'd2, 1, 16'h330C, 0);
        // R9: only writer 0 remains
        step("R9 after write", 2'd3, 4'd1, 2'd2, 1, 16'h0001, 0);
        // R6 broadcast
        step("R1 clear", 2'd2, 4'd0, 2'd0, 0, 0, 0);
        step("R2 add", 2'd1, 4'd1, 2'd0, 0, 0, 0);
        step("R2 add", 2'd1, 4'd2, 2'd0, 0, 0, 0);
        step("R6 overflow", 2'd1, 4'd3, 2'd0, 0, 0, 1);
        step("R6 add ignored", 2'd1, 4'd9, 2'd2, 0, 0, 1);
        step("R6 bcast write", 2'd3, 4'd5, 2'd0, 1, 16'hFFDF, 0);
        // R7 evict round robin
        step("R1 clear", 2'd2, 4'd0, 2'd1, 0, 0, 0);
        step("R2 add", 2'd1, 4'd1, 2'd1, 0, 0, 0);
        step("R2 add", 2'd1, 4'd2, 2'd1, 0, 0, 0);
        step("R7 evict slot0", 2'd1, 4'd7, 2'd1, 1, 16'h0002, 0);
        step("R7 evict slot1", 2'd1, 4'd9, 2'd1, 1, 16'h0004, 0);
        step("R8 write by 15", 2'd3, 4'd15, 2'd1, 1, 16'h0280, 0);
        step("R8 writer present", 2'd3, 4'd15, 2'd1, 1, 16'h0000, 0);
        step("R1 clear", 2'd2, 4'd0, 2'd0, 0, 0, 0);

        model_clear();
        for (int i = 0; i < 4000; i++) begin
            int r = $urandom_range(0, 99);
            logic [1:0] op;
            if (r < 55) op = 2'd1;
            else if (r < 72) op = 2'd3;
            else if (r < 78) op = 2'd2;
            else op = 2'd0;
            run(op, 4'($urandom_range(0, 15)), 2'($urandom_range(0, 3)));
        end

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule